// File: doc/BRIEF.md
# Programmable-Step 64-bit Machine Timer

This block is a memory-mapped machine timer for a single processor core. A 64-bit tick counter advances by a programmable step each time a programmable prescaler wraps. The counter runs only while the control register's run bit is set. The core programs a 64-bit compare value through a 32-bit word port. Whenever the running counter is at or past the compare value, the block drives a raw machine-timer line.

A second interrupt line is driven by a sticky status bit. That bit is set on a compare hit, or by a software test write, and only while the interrupt enable bit is on. Software clears it by writing one to it.

Software may load the counter only while the timer is stopped. Reading the low counter word captures the high word, so the next high-word read returns a value consistent with that low word.

Top module: `tmr_top`

## Requirements
- R1: After reset, the config word (0x100) reads 0x00010000, both compare words (0x10C low, 0x110 high) read 0xFFFFFFFF, and control (0x004), enable (0x114) and status (0x118) read 0. The outputs mtip_o and irq_o are low.
- R2: While control bit 0 is 0, the counter holds its value.
- R3: The config word has the prescale P in bits [11:0] and the step S in bits [23:16]. Once control bit 0 is set, the counter adds S at every (P+1)-th rising edge, counted from the edge after the one that wrote the run bit. The prescaler restarts from zero whenever the timer is stopped.
- R4: The counter words (0x104 low, 0x108 high) are writable only while the timer is stopped. A write while it runs is ignored.
- R5: A read of 0x104 captures the current high counter word. A read of 0x108 returns the value captured by the last low read. Carries from the low word propagate into the high word.
- R6: mtip_o goes high one cycle after the timer is running and the 64-bit counter is greater than or equal to the 64-bit compare value. It goes low one cycle after the compare moves above the counter, or one cycle after the timer stops.
- R7: Status bit 0 is set on a compare hit only when enable bit 0 is 1. irq_o reflects status bit 0 and rises together with mtip_o. With enable at 0, irq_o stays low even when mtip_o is high.
- R8: Status bit 0 is sticky. Writing 1 to it at 0x118 clears it. Writing 0 to it leaves it unchanged.
- R9: Writing 1 to bit 0 of the test word (0x11C) sets status bit 0 only when enable bit 0 is 1.
- R10: The write-only words (0x000, 0x11C) and unmapped offsets read 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one word per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address within the 1 KiB window (aligned) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational for the current request |
| mtip_o | output | 1 | Raw machine-timer interrupt |
| irq_o | output | 1 | Enabled, sticky timer interrupt |

## Verification
A wrong prescaler phase or a wrong step shows up as a counter value off by one step. It is visible at the first read after the timer is stopped, because the run window is counted edge by edge. A faulty comparator or a stale compare word shows on mtip_o exactly one cycle after the offending write. A status bit that is set when it should not be, or is lost, shows on irq_o in that same cycle and persists until a clear. Snapshot faults appear on the first high-word read after a low-word read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int CNT_W   = 64;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 10;
    parameter int PRESC_W = 12;
    parameter int STEP_W  = 8;
    localparam int STEP_LSB = 16;

    // word-aligned byte offsets
    localparam logic [ADDR_W-1:0] OFS_ALERT  = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 10'h100;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h104;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h108;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO = 10'h10C;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI = 10'h110;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 10'h114;
    localparam logic [ADDR_W-1:0] OFS_IST    = 10'h118;
    localparam logic [ADDR_W-1:0] OFS_ITEST  = 10'h11C;

    typedef struct packed {
        logic               active;
        logic [PRESC_W-1:0] presc;
        logic [STEP_W-1:0]  step;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   cmp;
        logic               ien;
        logic               ist;
        logic               mtip;
        logic [DATA_W-1:0]  snap;
    } tmr_state_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    logic [W-1:0] pc_d, pc_q;

    always_comb begin
        tick_o = run_i && (pc_q >= limit_i);
        if (!run_i || tick_o) pc_d = '0;
        else                  pc_d = pc_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pc_q <= '0;
        else         pc_q <= pc_d;
    end
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         ge_o
);
    localparam int HALF = W / 2;
    generate
        if (W > 32) begin : g_split
            // compare halves in parallel, combine with the upper-half result
            logic hi_gt, hi_eq, lo_ge;
            assign hi_gt = a_i[W-1:HALF] >  b_i[W-1:HALF];
            assign hi_eq = a_i[W-1:HALF] == b_i[W-1:HALF];
            assign lo_ge = a_i[HALF-1:0] >= b_i[HALF-1:0];
            assign ge_o  = hi_gt || (hi_eq && lo_ge);
        end else begin : g_flat
            assign ge_o = a_i >= b_i;
        end
    endgenerate
endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mtip_o,
    output logic              irq_o
);
    localparam int HI = CNT_W - 1;
    localparam int LO_TOP = DATA_W - 1;

    tmr_state_t st_d, st_q;
    logic tick, hit, wr, rd;
    logic [ADDR_W-1:0] word;

    tmr_prescale #(.W(PRESC_W)) u_presc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st_q.active),
        .limit_i (st_q.presc),
        .tick_o  (tick)
    );

    tmr_cmp #(.W(CNT_W)) u_cmp (
        .a_i  (st_q.cnt),
        .b_i  (st_q.cmp),
        .ge_o (hit)
    );

    always_comb begin
        word = {addr_i[ADDR_W-1:2], 2'b00};
        wr   = req_i && we_i;
        rd   = req_i && !we_i;
        st_d = st_q;

        if (tick) st_d.cnt = st_q.cnt + {{(CNT_W-STEP_W){1'b0}}, st_q.step};

        if (wr) begin
            case (word)
                OFS_CTRL:   st_d.active = wdata_i[0];
                OFS_CFG: begin
                    st_d.presc = wdata_i[PRESC_W-1:0];
                    st_d.step  = wdata_i[STEP_LSB+STEP_W-1:STEP_LSB];
                end
                OFS_CNT_LO: if (!st_q.active) st_d.cnt[LO_TOP:0]   = wdata_i;
                OFS_CNT_HI: if (!st_q.active) st_d.cnt[HI:DATA_W]  = wdata_i;
                OFS_CMP_LO: st_d.cmp[LO_TOP:0]  = wdata_i;
                OFS_CMP_HI: st_d.cmp[HI:DATA_W] = wdata_i;
                OFS_IEN:    st_d.ien = wdata_i[0];
                OFS_IST:    if (wdata_i[0]) st_d.ist = 1'b0;
                default: ;
            endcase
        end

        // a set event wins over a same-cycle clear
        if ((st_q.active && hit && st_q.ien) ||
            (wr && word == OFS_ITEST && wdata_i[0] && st_q.ien))
            st_d.ist = 1'b1;

        st_d.mtip = st_q.active && hit;

        if (rd && word == OFS_CNT_LO) st_d.snap = st_q.cnt[HI:DATA_W];

        rdata_o = '0;
        if (rd) begin
            case (word)
                OFS_CTRL:   rdata_o = {{(DATA_W-1){1'b0}}, st_q.active};
                OFS_CFG: begin
                    rdata_o[PRESC_W-1:0] = st_q.presc;
                    rdata_o[STEP_LSB+STEP_W-1:STEP_LSB] = st_q.step;
                end
                OFS_CNT_LO: rdata_o = st_q.cnt[LO_TOP:0];
                OFS_CNT_HI: rdata_o = st_q.snap;
                OFS_CMP_LO: rdata_o = st_q.cmp[LO_TOP:0];
                OFS_CMP_HI: rdata_o = st_q.cmp[HI:DATA_W];
                OFS_IEN:    rdata_o = {{(DATA_W-1){1'b0}}, st_q.ien};
                OFS_IST:    rdata_o = {{(DATA_W-1){1'b0}}, st_q.ist};
                default:    rdata_o = '0;
            endcase
        end

        mtip_o = st_q.mtip;
        irq_o  = st_q.ist;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.step   <= STEP_W'(1);
            st_q.cmp    <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              mtip_o,
    input logic              irq_o,
    input tmr_state_t        st_q
);
    logic [ADDR_W-1:0] w;
    logic cnt_wr, clr_wr, mapped_rd;
    assign w      = {addr_i[ADDR_W-1:2], 2'b00};
    assign cnt_wr = req_i && we_i && (w == OFS_CNT_LO || w == OFS_CNT_HI);
    assign clr_wr = req_i && we_i && w == OFS_IST && wdata_i[0];
    assign mapped_rd = w == OFS_CTRL || w == OFS_CFG || w == OFS_CNT_LO ||
                       w == OFS_CNT_HI || w == OFS_CMP_LO || w == OFS_CMP_HI ||
                       w == OFS_IEN || w == OFS_IST;

    p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.active && !cnt_wr) |=> $stable(st_q.cnt));

    p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.active |=> (st_q.cnt == $past(st_q.cnt)) ||
                        (st_q.cnt == $past(st_q.cnt) + CNT_W'($past(st_q.step))));

    p_mtip_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.active |=> !mtip_o);

    p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(st_q.ien));

    p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !clr_wr) |=> irq_o);

    p_rd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && !mapped_rd) |-> rdata_o == '0);
endmodule

bind tmr_top tmr_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .mtip_o  (mtip_o),
    .irq_o   (irq_o),
    .st_q    (st_q)
);

// File: tb/tmr_top_tb_top.sv
`timescale 1ns/1ps
module tmr_top_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req = 0, we = 0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        mtip, irq;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .mtip_o(mtip), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // each access occupies exactly one rising edge; called and returns at a negedge
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        req = 1; we = 1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        req = 1; we = 0; addr = a;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 mtip", {31'b0, mtip}, 0);
        check("R1 irq", {31'b0, irq}, 0);
        rd(10'h100, v); check("R1 cfg", v, 32'h00010000);
        rd(10'h10C, v); check("R1 cmp lo", v, 32'hFFFFFFFF);
        rd(10'h110, v); check("R1 cmp hi", v, 32'hFFFFFFFF);
        rd(10'h004, v); check("R1 ctrl", v, 0);
        rd(10'h114, v); check("R1 ien", v, 0);
        rd(10'h118, v); check("R1 ist", v, 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(10'h200, 32'hFFFFFFFF);
        rd(10'h200, v); check("R10 unmapped read", v, 0);
        rd(10'h100, v); check("R10 unmapped write ignored", v, 32'h00010000);
        rd(10'h000, v); check("R10 alert word reads 0", v, 0);
        rd(10'h11C, v); check("R10 test word reads 0", v, 0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(10'h104, 0); wr(10'h108, 0);
        wr(10'h100, 32'h0005_0002);          // P=2, S=5
        wr(10'h004, 1);
        idle(9);                              // 10 active edges incl. stop edge
        wr(10'h004, 0);
        rd(10'h104, v); check("R3 prescaled count", v, 32'd15);
        idle(5);
        rd(10'h104, v); check("R2 held lo", v, 32'd15);
        rd(10'h108, v); check("R2 held hi", v, 0);
    endtask

    task automatic t_locked;
        logic [31:0] v;
        wr(10'h100, 32'h0003_0000);          // P=0, S=3
        wr(10'h104, 32'h10);
        wr(10'h004, 1);
        wr(10'h104, 32'hDEAD);               // ignored while running
        wr(10'h004, 0);
        rd(10'h104, v); check("R4 write while running ignored", v, 32'h16);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        wr(10'h100, 32'h0001_0000);
        wr(10'h104, 32'hFFFFFFFE); wr(10'h108, 5);
        wr(10'h004, 1);
        idle(1);
        wr(10'h004, 0);
        rd(10'h104, v); check("R5 carry lo", v, 0);
        rd(10'h108, v); check("R5 carry hi", v, 6);
        wr(10'h108, 9);
        rd(10'h108, v); check("R5 snapshot kept", v, 6);
        rd(10'h104, v);
        rd(10'h108, v); check("R5 snapshot refreshed", v, 9);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(10'h104, 100); wr(10'h108, 0);
        wr(10'h10C, 100); wr(10'h110, 0);
        wr(10'h114, 1);
        check("R6 no mtip while stopped", {31'b0, mtip}, 0);
        wr(10'h004, 1);
        idle(1);
        check("R6 mtip on hit", {31'b0, mtip}, 1);
        check("R7 irq on enabled hit", {31'b0, irq}, 1);
        wr(10'h110, 32'hFFFFFFFF);
        idle(1);
        check("R6 mtip drops after compare raised", {31'b0, mtip}, 0);
        check("R8 irq sticky", {31'b0, irq}, 1);
        wr(10'h118, 0);
        check("R8 write 0 keeps status", {31'b0, irq}, 1);
        wr(10'h118, 1);
        check("R8 w1c clears", {31'b0, irq}, 0);
        wr(10'h114, 0);
        wr(10'h11C, 1);
        rd(10'h118, v); check("R9 test ignored when disabled", v, 0);
        wr(10'h114, 1);
        wr(10'h11C, 1);
        check("R9 test sets irq", {31'b0, irq}, 1);
        wr(10'h118, 1);
        wr(10'h114, 0);
        wr(10'h110, 0);
        idle(2);
        check("R7 mtip with enable off", {31'b0, mtip}, 1);
        check("R7 irq gated by enable", {31'b0, irq}, 0);
        wr(10'h004, 0);
        idle(1);
        check("R6 mtip drops when stopped", {31'b0, mtip}, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        t_reset();
        t_map();
        t_prescale();
        t_locked();
        t_snapshot();
        t_irq();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule